// File: doc/BRIEF.md
# Compare Match Interval Timer

The block is a 16-bit interval timer. It counts a divided form of its own clock and raises a flag when the count reaches a constant that software has programmed. The division ratio can be 4, 8, 16 or 64. On every match the counter starts again from zero, the flag is set and held, and a single-cycle pulse is issued. A DMA channel uses that pulse as a request, so software can pace transfers at a fixed rate.

Software reaches the timer through a small register port with four halfword registers, selected by `addr`:

- index 0 holds the run bit.
- index 1 holds the flag and the divider select.
- index 2 holds the live count.
- index 3 holds the compare constant.

Reads are combinational. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `match_interval_timer`

## Requirements
- R1: After reset `match_flag` and `dma_req` are 0. The run register reads 0, the control register reads 0, the counter reads 0 and the constant reads 16'hFFFF.
- R2: Register index 0 bit 0 controls counting: 1 runs the timer and 0 stops it. While the timer is stopped the counter holds its value.
- R3: Control register (index 1) bits 1:0 set the divider: 00 divides by 4, 01 by 8, 10 by 16 and 11 by 64. Take a stopped timer with count 0 and constant C. The flag rises exactly (C+1)×ratio clock edges after the edge that writes the run bit to 1.
- R4: On each divided tick the counter goes up by one. A tick that finds the counter equal to the constant loads 0 instead, and that tick is a match.
- R5: A match sets `match_flag`, which is also control bit 7. Two control writes have no effect on the flag: writing bit 7 = 0 before the flag has been read as 1, and writing bit 7 = 1 at any time.
- R6: Reading the control register while the flag is 1 arms it. A later control write with bit 7 = 0 then clears the flag.
- R7: `dma_req` is high for exactly one cycle per match, in the same cycle that the flag first shows the match.
- R8: Stopping the timer resets the divider. After a restart a full divided interval elapses before the first tick.
- R9: A write to the counter (index 2) takes effect at its own edge. It overrides an increment that falls on the same edge.
- R10: When a match and an armed clear fall on the same edge, the match wins and the flag stays 1.
- R11: Writes to index 3 set the constant and reads return it. Reads of index 2 return the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 2 | Register index: 0 run, 1 control, 2 count, 3 constant |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| match_flag | output | 1 | Sticky compare match flag |
| dma_req | output | 1 | One-cycle request pulse per match |

## Verification
Two pairs of events can coincide. The first is a match and an armed clear of the flag. To provoke it, a stopped timer with count 0 and constant 0 is started, and the clearing write is placed on the fourth edge after the start. The flag must still read 1 and `dma_req` must be high. The second is a counter write and a divided tick. A write is landed on a tick edge, and the readback must show the written value, not the value plus one.

// File: rtl/mit_pkg.sv
package mit_pkg;

  localparam int DATA_W   = 16;
  localparam int PRE_W    = 6;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    REG_RUN   = 2'd0,
    REG_CTRL  = 2'd1,
    REG_COUNT = 2'd2,
    REG_CONST = 2'd3
  } mit_reg_e;

  typedef enum logic [1:0] {
    DIV_4  = 2'd0,
    DIV_8  = 2'd1,
    DIV_16 = 2'd2,
    DIV_64 = 2'd3
  } mit_div_e;

  // Terminal value of the divider counter: ratio minus one.
  function automatic logic [PRE_W-1:0] div_last(input mit_div_e sel);
    case (sel)
      DIV_4:   div_last = PRE_W'(3);
      DIV_8:   div_last = PRE_W'(7);
      DIV_16:  div_last = PRE_W'(15);
      default: div_last = PRE_W'(63);
    endcase
  endfunction

  // Next counter value on a tick: wrap to zero at the constant.
  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] lim);
    count_step = (cur == lim) ? '0 : cur + DATA_W'(1);
  endfunction

  // Control register image seen by software.
  function automatic logic [DATA_W-1:0] ctrl_image(input logic flag, input mit_div_e sel);
    logic [DATA_W-1:0] img;
    img = '0;
    img[FLAG_BIT] = flag;
    img[1:0] = sel;
    return img;
  endfunction

endpackage

// File: rtl/mit_prescaler.sv
module mit_prescaler
  import mit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  mit_div_e sel,
  output logic     tick
);

  logic [PRE_W-1:0] pre_q;

  // ">=" keeps a mid-run change to a smaller ratio from skipping a wrap.
  assign tick = run && (pre_q >= div_last(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

endmodule

// File: rtl/mit_counter.sv
module mit_counter
  import mit_pkg::*;
#(
  parameter logic [DATA_W-1:0] CONST_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_count,
  input  logic              wr_const,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] limit,
  output logic              match_evt
);

  logic [DATA_W-1:0] count_q, limit_q;

  // A software write to the counter overrides the tick, including its match.
  assign match_evt = tick && !wr_count && (count_q == limit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (wr_count) count_q <= wdata;
    else if (tick)     count_q <= count_step(count_q, limit_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= CONST_INIT;
    else if (wr_const) limit_q <= wdata;
  end

  assign count = count_q;
  assign limit = limit_q;

endmodule

// File: rtl/mit_flag.sv
module mit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match_evt,
  input  logic rd_ctrl,
  input  logic clr_req,
  output logic flag,
  output logic req_pulse
);

  logic flag_q, armed_q, req_q;
  logic clr_ok;

  assign clr_ok = clr_req && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= match_evt;
      if (match_evt)   flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      if (clr_req)                armed_q <= 1'b0;
      else if (rd_ctrl && flag_q) armed_q <= 1'b1;
    end
  end

  assign flag      = flag_q;
  assign req_pulse = req_q;

endmodule

// File: rtl/match_interval_timer.sv
module match_interval_timer
  import mit_pkg::*;
#(
  parameter logic [DATA_W-1:0] CONST_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              match_flag,
  output logic              dma_req
);

  mit_reg_e          reg_sel;
  logic              run_q;
  mit_div_e          sel_q;
  logic              tick;
  logic              match_evt;
  logic              wr_count, wr_const, wr_ctrl, wr_run, rd_ctrl, clr_req;
  logic [DATA_W-1:0] count, limit;

  assign reg_sel  = mit_reg_e'(addr);
  assign wr_run   = wr_en && (reg_sel == REG_RUN);
  assign wr_ctrl  = wr_en && (reg_sel == REG_CTRL);
  assign wr_count = wr_en && (reg_sel == REG_COUNT);
  assign wr_const = wr_en && (reg_sel == REG_CONST);
  assign rd_ctrl  = rd_en && (reg_sel == REG_CTRL);
  assign clr_req  = wr_ctrl && !wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= DIV_4;
    end else begin
      if (wr_run)  run_q <= wdata[0];
      if (wr_ctrl) sel_q <= mit_div_e'(wdata[1:0]);
    end
  end

  mit_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .sel  (sel_q),
    .tick (tick)
  );

  mit_counter #(.CONST_INIT(CONST_INIT)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_count (wr_count),
    .wr_const (wr_const),
    .wdata    (wdata),
    .count    (count),
    .limit    (limit),
    .match_evt(match_evt)
  );

  mit_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_evt(match_evt),
    .rd_ctrl  (rd_ctrl),
    .clr_req  (clr_req),
    .flag     (match_flag),
    .req_pulse(dma_req)
  );

  always_comb begin
    case (reg_sel)
      REG_RUN:   rdata = {{(DATA_W-1){1'b0}}, run_q};
      REG_CTRL:  rdata = ctrl_image(match_flag, sel_q);
      REG_COUNT: rdata = count;
      default:   rdata = limit;
    endcase
  end

endmodule

// File: rtl/mit_checker.sv
module mit_checker
  import mit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              tick,
  input logic              match_evt,
  input logic              wr_count,
  input logic              clr_req,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] count,
  input logic              match_flag,
  input logic              dma_req
);

  // R7: a match shows as flag and request on the following cycle
  a_r7_match_to_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (match_flag && dma_req));

  // R7: the request never lasts longer than one cycle
  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  // R2: a stopped timer keeps its count unless software writes it
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_count) |=> $stable(count));

  // R8: the divider produces no tick while stopped
  a_r8_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run_q);

  // R5: the flag drops only after a clearing write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_req) |=> match_flag);

  // R9: a counter write lands at its own edge
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count == $past(wdata)));

endmodule

bind match_interval_timer mit_checker u_mit_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .tick      (tick),
  .match_evt (match_evt),
  .wr_count  (wr_count),
  .clr_req   (clr_req),
  .wdata     (wdata),
  .count     (count),
  .match_flag(match_flag),
  .dma_req   (dma_req)
);

// File: tb/test_match_interval_timer.sv
module test_match_interval_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        match_flag;
  logic        dma_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  match_interval_timer i_match_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .match_flag(match_flag), .dma_req(dma_req)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] cst;
    logic [31:0] period;
  } vec_t;

  // period = (constant + 1) * ratio, ratio from sel: 4, 8, 16, 64
  localparam vec_t VEC [8] = '{
    '{2'd0, 16'd0, 32'd4},
    '{2'd0, 16'd5, 32'd24},
    '{2'd1, 16'd3, 32'd32},
    '{2'd2, 16'd2, 32'd48},
    '{2'd3, 16'd1, 32'd128},
    '{2'd3, 16'd0, 32'd64},
    '{2'd1, 16'd0, 32'd8},
    '{2'd2, 16'd7, 32'd128}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_flag(output int cyc);
    cyc = 0;
    while (!match_flag && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, a;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flag", int'(match_flag), 0);
    check("R1 req", int'(dma_req), 0);
    rd(2'd0, d); check("R1 run reg", int'(d), 0);
    rd(2'd1, d); check("R1 ctrl reg", int'(d), 0);
    rd(2'd2, d); check("R1 count", int'(d), 0);
    rd(2'd3, d); check("R1 const", int'(d), 16'hFFFF);

    // R3 R4 R7 R11: vector table
    foreach (VEC[i]) begin
      wr(2'd3, VEC[i].cst);
      rd(2'd3, d); check("R11 const readback", int'(d), int'(VEC[i].cst));
      wr(2'd1, {14'd0, VEC[i].sel});
      wr(2'd2, 16'd0);
      wr(2'd0, 16'd1);
      wait_flag(cyc);
      check("R3 period", cyc, int'(VEC[i].period));
      check("R7 req with flag", int'(dma_req), 1);
      rd(2'd2, d); check("R4 count wraps to 0", int'(d), 0);
      check("R7 req one cycle", int'(dma_req), 0);
      wr(2'd0, 16'd0);
      rd(2'd1, d); check("R5 ctrl bit7 set", int'(d[7]), 1);
      check("R11 ctrl sel bits", int'(d[1:0]), int'(VEC[i].sel));
      wr(2'd1, {14'd0, VEC[i].sel});
      check("R6 armed clear", int'(match_flag), 0);
    end

    // R2 stop freezes counter, R4 increments per tick
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd1000);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd1);
    repeat (20) @(negedge clk);
    wr(2'd0, 16'd0);
    rd(2'd2, a); check("R4 five ticks", int'(a), 5);
    repeat (10) @(negedge clk);
    rd(2'd2, d); check("R2 frozen count", int'(d), int'(a));
    rd(2'd0, d); check("R2 run reg reads 0", int'(d), 0);

    // R9 counter write on a tick edge wins
    wr(2'd0, 16'd1);
    repeat (3) @(negedge clk);
    wr(2'd2, 16'd100);
    rd(2'd2, d); check("R9 write beats tick", int'(d), 100);
    repeat (3) @(negedge clk);
    rd(2'd2, d); check("R9 counts on from written value", int'(d), 101);
    wr(2'd0, 16'd0);

    // R8 stop resets the divider (ratio 64, constant 0)
    wr(2'd1, 16'd3);
    wr(2'd3, 16'd0);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd1);
    repeat (39) @(negedge clk);
    wr(2'd0, 16'd0);
    check("R8 no match before stop", int'(match_flag), 0);
    wr(2'd0, 16'd1);
    wait_flag(cyc);
    check("R8 full interval after restart", cyc, 64);
    wr(2'd0, 16'd0);
    rd(2'd1, d);
    wr(2'd1, 16'd0);
    check("R6 clear after R8", int'(match_flag), 0);

    // R5 unarmed clear and write of 1 are ignored
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd1);
    wait_flag(cyc);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    check("R5 unarmed clear ignored", int'(match_flag), 1);
    wr(2'd1, 16'h0080);
    check("R5 writing 1 no effect", int'(match_flag), 1);
    rd(2'd1, d); check("R5 flag reads 1", int'(d[7]), 1);
    wr(2'd1, 16'd0);
    check("R6 read then clear", int'(match_flag), 0);

    // R10 match and armed clear on the same edge
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd1);
    wait_flag(cyc);
    wr(2'd0, 16'd0);
    rd(2'd1, d);
    wr(2'd0, 16'd1);
    repeat (3) @(negedge clk);
    wr(2'd1, 16'd0);
    check("R10 match wins over clear", int'(match_flag), 1);
    check("R10 request issued", int'(dma_req), 1);
    wr(2'd0, 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule